// File: doc/BRIEF.md
# Dual-Mode Error Signal Monitor

This block supervises an active-low fault line driven by a host microcontroller and raises a single error flag. The line is synchronised and passed through a programmable deglitch filter. Two behaviours are selectable. In level mode, a filtered low level is the error. In PWM mode, the high and low time of every period of a toggling line is measured in ticks of a slow time-base strobe and compared with programmable windows. Each period is scored as a good or a bad event, and a weighted error counter rises fast on faults and falls slowly on healthy periods.

Software reaches the block through a generic register write/read port. A power-on default sets whether the monitor may run. A start bit arms monitoring. While the monitor runs, its settings are locked against change. A separate driver-enable bit is only accepted in states where changing it is safe.

Top module: `esm_mon`

## Requirements
- R1: After reset the start bit, driver-enable and error counter are 0, `err_o` is 0, and the enable bit equals parameter `EN_RST` (default 1). Register 0 reads {en[2], drv[1], start[0]} and register 8 reads the counter in its low 5 bits.
- R2: With the enable bit (register 0 bit 2) at 0, `err_o` stays 0 and the counter does not move, whatever the input does.
- R3: Monitoring happens only while both start (register 0 bit 0) and enable are 1. Clearing start drops `err_o` and freezes the counter.
- R4: While start is 1, writes to registers 1 to 7 (mode, deglitch time, threshold, high max, high min, low max, low min) and to the enable bit are ignored. Start itself stays writable.
- R5: A write to driver-enable (register 0 bit 1) takes effect only if, before the write, start is 1 or enable is 0. Otherwise it is ignored.
- R6: The filtered level takes a new value only after the synchronised input has held that value for deglitch+1 clock cycles. Shorter pulses are dropped.
- R7: In level mode (register 1 bit 0 = 0), `err_o` is 1 while the monitor runs and the filtered level is low.
- R8: In PWM mode (register 1 bit 0 = 1), a period runs from one filtered rising edge to the next. It is good when its high-tick count lies in [hmin,hmax] and its low-tick count lies in [lmin,lmax]. Otherwise it is bad.
- R9: The 5-bit counter adds 2 per bad event and subtracts 1 per good event, saturating at 31 and at 0.
- R10: In PWM mode, `err_o` is 1 while the monitor runs and the counter exceeds the threshold (register 3).
- R11: A high or low phase whose tick count exceeds its maximum is a bad event at once. It repeats every time the limit is exceeded again, and the period is not graded again at its next rising edge.
- R12: A write that moves start from 0 to 1 clears the counter in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_ni | input | 1 | Monitored fault line, active low |
| tick_i | input | 1 | Time-base strobe for pulse-width measurement |
| we_i | input | 1 | Register write strobe |
| waddr_i | input | AW | Write address |
| wdata_i | input | DW | Write data |
| raddr_i | input | AW | Read address |
| rdata_o | output | DW | Read data (combinational) |
| err_o | output | 1 | Error flag |
| drv_en_o | output | 1 | Driver-enable bit |

## Verification
Assertions check on every cycle that the settings and the enable bit hold while started, that driver-enable only rises in an allowed state, that the filter only adopts a level the synchroniser presents, that the counter only moves by +2, -1, or to a rail, and that it is clear after a start. Only the bench scenarios can show window grading with real tick streams, repeated overrun faults on a stuck line, the threshold crossing and the silence of a disabled monitor. These behaviours are compared cycle by cycle against a behavioural model.

// File: rtl/esm_pkg.sv
package esm_pkg;
  localparam int CFG_W = 8;
  localparam int ADR_W = 4;

  localparam logic [ADR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADR_W-1:0] A_MODE = 4'd1;
  localparam logic [ADR_W-1:0] A_DEGL = 4'd2;
  localparam logic [ADR_W-1:0] A_THR  = 4'd3;
  localparam logic [ADR_W-1:0] A_HMAX = 4'd4;
  localparam logic [ADR_W-1:0] A_HMIN = 4'd5;
  localparam logic [ADR_W-1:0] A_LMAX = 4'd6;
  localparam logic [ADR_W-1:0] A_LMIN = 4'd7;
  localparam logic [ADR_W-1:0] A_STAT = 4'd8;

  typedef enum logic [1:0] {PH_IDLE, PH_HIGH, PH_LOW} phase_e;

  typedef struct packed {
    logic             mode;
    logic [CFG_W-1:0] degl;
    logic [CFG_W-1:0] thr;
    logic [CFG_W-1:0] hmax;
    logic [CFG_W-1:0] hmin;
    logic [CFG_W-1:0] lmax;
    logic [CFG_W-1:0] lmin;
  } cfg_t;
endpackage

// File: rtl/esm_regs.sv
module esm_regs
  import esm_pkg::*;
#(
  parameter bit EN_RST = 1'b1,
  parameter int AW     = ADR_W,
  parameter int DW     = CFG_W,
  parameter int CNT_W  = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  input  logic [CNT_W-1:0] cnt_i,
  output logic          en_o,
  output logic          start_o,
  output logic          drv_o,
  output logic          start_set_o,
  output cfg_t          cfg_o
);
  logic en_q, start_q, drv_q;
  cfg_t cfg_q;
  logic ctrl_wr, cfg_wr;

  assign ctrl_wr = we_i && (waddr_i == A_CTRL);
  assign cfg_wr  = we_i && !start_q;
  assign start_set_o = ctrl_wr && wdata_i[0] && !start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= EN_RST;
      start_q <= 1'b0;
      drv_q   <= 1'b0;
      cfg_q   <= '{mode: 1'b0, degl: DW'(4), thr: DW'(4), hmax: DW'(20),
                   hmin: DW'(1), lmax: DW'(20), lmin: DW'(1)};
    end else begin
      if (ctrl_wr) begin
        start_q <= wdata_i[0];
        if (start_q || !en_q) drv_q <= wdata_i[1];
        if (!start_q) en_q <= wdata_i[2];
      end
      if (cfg_wr) begin
        case (waddr_i)
          A_MODE: cfg_q.mode <= wdata_i[0];
          A_DEGL: cfg_q.degl <= wdata_i;
          A_THR:  cfg_q.thr  <= wdata_i;
          A_HMAX: cfg_q.hmax <= wdata_i;
          A_HMIN: cfg_q.hmin <= wdata_i;
          A_LMAX: cfg_q.lmax <= wdata_i;
          A_LMIN: cfg_q.lmin <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (raddr_i)
      A_CTRL: rdata_o[2:0] = {en_q, drv_q, start_q};
      A_MODE: rdata_o[0]   = cfg_q.mode;
      A_DEGL: rdata_o      = cfg_q.degl;
      A_THR:  rdata_o      = cfg_q.thr;
      A_HMAX: rdata_o      = cfg_q.hmax;
      A_HMIN: rdata_o      = cfg_q.hmin;
      A_LMAX: rdata_o      = cfg_q.lmax;
      A_LMIN: rdata_o      = cfg_q.lmin;
      A_STAT: rdata_o[CNT_W-1:0] = cnt_i;
      default: ;
    endcase
  end

  assign en_o    = en_q;
  assign start_o = start_q;
  assign drv_o   = drv_q;
  assign cfg_o   = cfg_q;

  AST_CFG_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> $stable(cfg_q)); // R4
  AST_EN_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> $stable(en_q)); // R4
  AST_DRV_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_q) |-> $past(start_q || !en_q)); // R5
endmodule

// File: rtl/esm_degl.sv
module esm_degl #(
  parameter int DW     = 8,
  parameter int SYNC_W = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_i,
  input  logic [DW-1:0] degl_i,
  output logic          flt_o
);
  logic [SYNC_W-1:0] sync_q;
  logic              flt_q;
  logic [DW-1:0]     dcnt_q;
  logic              s_lvl;

  assign s_lvl = sync_q[SYNC_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      flt_q  <= 1'b1;
      dcnt_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_W-2:0], in_i};
      if (s_lvl == flt_q) begin
        dcnt_q <= '0;
      end else if (dcnt_q >= degl_i) begin
        flt_q  <= s_lvl;
        dcnt_q <= '0;
      end else begin
        dcnt_q <= dcnt_q + 1'b1;
      end
    end
  end

  assign flt_o = flt_q;

  AST_DEGL_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_q != $past(flt_q)) |-> ($past(s_lvl) == flt_q)); // R6
endmodule

// File: rtl/esm_pwm.sv
module esm_pwm
  import esm_pkg::*;
#(
  parameter int DW    = CFG_W,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             flt_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [DW-1:0]    hmax_i,
  input  logic [DW-1:0]    hmin_i,
  input  logic [DW-1:0]    lmax_i,
  input  logic [DW-1:0]    lmin_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [DW-1:0]    W_MAX = '1;
  localparam logic [CNT_W-1:0] C_MAX = '1;
  localparam logic [CNT_W-1:0] C_TOP = C_MAX - CNT_W'(2);

  phase_e          ph_q, ph_n;
  logic [DW-1:0]   w_q, w_n;
  logic            skip_q, skip_n, hok_q, hok_n, lvl_q;
  logic            rise, fall, good, bad;
  logic [CNT_W-1:0] cnt_q;

  assign rise = flt_i & ~lvl_q;
  assign fall = ~flt_i & lvl_q;

  always_comb begin
    ph_n   = ph_q;
    skip_n = skip_q;
    hok_n  = hok_q;
    w_n    = (tick_i && w_q != W_MAX) ? w_q + 1'b1 : w_q;
    good   = 1'b0;
    bad    = 1'b0;
    if (!run_i) begin
      ph_n = PH_IDLE; w_n = '0; skip_n = 1'b0; hok_n = 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: if (rise) begin
          ph_n = PH_HIGH; w_n = '0; skip_n = 1'b0;
        end
        PH_HIGH: if (fall) begin
          hok_n = (w_q >= hmin_i) && (w_q <= hmax_i);
          ph_n  = PH_LOW; w_n = '0;
        end else if (w_q > hmax_i) begin
          bad = 1'b1; skip_n = 1'b1; w_n = '0;
        end
        PH_LOW: if (rise) begin
          if (!skip_q) begin
            if (hok_q && w_q >= lmin_i && w_q <= lmax_i) good = 1'b1;
            else bad = 1'b1;
          end
          ph_n = PH_HIGH; w_n = '0; skip_n = 1'b0;
        end else if (w_q > lmax_i) begin
          bad = 1'b1; skip_n = 1'b1; w_n = '0;
        end
        default: ph_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_IDLE; w_q <= '0; skip_q <= 1'b0; hok_q <= 1'b0;
      lvl_q <= 1'b1; cnt_q <= '0;
    end else begin
      ph_q <= ph_n; w_q <= w_n; skip_q <= skip_n; hok_q <= hok_n;
      lvl_q <= flt_i;
      if (clr_i)                  cnt_q <= '0;
      else if (bad)               cnt_q <= (cnt_q > C_TOP) ? C_MAX : cnt_q + CNT_W'(2);
      else if (good && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  AST_EVT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({good, bad})); // R8
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == C_MAX ||
      int'(cnt_q) == int'($past(cnt_q)) + 2 || int'(cnt_q) + 1 == int'($past(cnt_q)))); // R9
  AST_CNT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R12
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/esm_mon.sv
module esm_mon
  import esm_pkg::*;
#(
  parameter bit EN_RST = 1'b1,
  parameter int AW     = ADR_W,
  parameter int DW     = CFG_W,
  parameter int CNT_W  = 5,
  parameter int SYNC_W = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          err_ni,
  input  logic          tick_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic          err_o,
  output logic          drv_en_o
);
  logic en, start, start_set, flt, run_pwm;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    cnt_ext;
  cfg_t cfg;

  esm_regs #(.EN_RST(EN_RST), .AW(AW), .DW(DW), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .waddr_i, .wdata_i, .raddr_i, .rdata_o,
    .cnt_i(cnt), .en_o(en), .start_o(start), .drv_o(drv_en_o),
    .start_set_o(start_set), .cfg_o(cfg)
  );

  esm_degl #(.DW(DW), .SYNC_W(SYNC_W)) u_degl (
    .clk_i, .rst_ni, .in_i(err_ni), .degl_i(cfg.degl), .flt_o(flt)
  );

  assign run_pwm = en & start & cfg.mode;

  esm_pwm #(.DW(DW), .CNT_W(CNT_W)) u_pwm (
    .clk_i, .rst_ni, .run_i(run_pwm), .flt_i(flt), .tick_i,
    .clr_i(start_set), .hmax_i(cfg.hmax), .hmin_i(cfg.hmin),
    .lmax_i(cfg.lmax), .lmin_i(cfg.lmin), .cnt_o(cnt)
  );

  always_comb begin
    cnt_ext = '0;
    cnt_ext[CNT_W-1:0] = cnt;
  end

  assign err_o = en & start & (cfg.mode ? (cnt_ext > cfg.thr) : ~flt);

  AST_ERR_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (en && start)); // R2
endmodule

// File: tb/esm_mon_tb.sv
module esm_mon_tb;
  localparam int AW = 4;
  localparam int DW = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0, err_ni = 1'b1, tick_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] waddr_i = '0, raddr_i = 4'd8;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic err_o, drv_en_o;

  int n_chk = 0, n_fail = 0, tick_per = 2, tick_cnt = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  esm_mon u_dut (.*);

  // behavioural model
  int m_en, m_start, m_drv, m_mode, m_degl, m_thr, m_hmax, m_hmin, m_lmax, m_lmin;
  int m_s1, m_s2, m_flt, m_dc, m_lvl, m_ph, m_w, m_skip, m_hok, m_cnt;
  int run, rise, fall, good, bad, nw, nph, nskip, nhok, ncnt, nflt, ndc;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = 1; m_start = 0; m_drv = 0; m_mode = 0; m_degl = 4; m_thr = 4;
      m_hmax = 20; m_hmin = 1; m_lmax = 20; m_lmin = 1;
      m_s1 = 1; m_s2 = 1; m_flt = 1; m_dc = 0; m_lvl = 1;
      m_ph = 0; m_w = 0; m_skip = 0; m_hok = 0; m_cnt = 0;
    end else begin
      run = m_en && m_start && m_mode;
      rise = m_flt && !m_lvl; fall = !m_flt && m_lvl;
      good = 0; bad = 0; nph = m_ph; nskip = m_skip; nhok = m_hok;
      nw = (tick_i && m_w < 255) ? m_w + 1 : m_w;
      if (!run) begin nph = 0; nw = 0; nskip = 0; nhok = 0; end
      else if (m_ph == 0) begin
        if (rise) begin nph = 1; nw = 0; nskip = 0; end
      end else if (m_ph == 1) begin
        if (fall) begin nhok = (m_w >= m_hmin && m_w <= m_hmax); nph = 2; nw = 0; end
        else if (m_w > m_hmax) begin bad = 1; nskip = 1; nw = 0; end
      end else begin
        if (rise) begin
          if (!m_skip) begin
            if (m_hok && m_w >= m_lmin && m_w <= m_lmax) good = 1; else bad = 1;
          end
          nph = 1; nw = 0; nskip = 0;
        end else if (m_w > m_lmax) begin bad = 1; nskip = 1; nw = 0; end
      end
      ncnt = m_cnt;
      if (we_i && waddr_i == 0 && wdata_i[0] && !m_start) ncnt = 0;
      else if (bad) ncnt = (m_cnt + 2 > 31) ? 31 : m_cnt + 2;
      else if (good && m_cnt > 0) ncnt = m_cnt - 1;
      nflt = m_flt; ndc = 0;
      if (m_s2 != m_flt) begin
        if (m_dc >= m_degl) nflt = m_s2; else ndc = m_dc + 1;
      end
      if (we_i) begin
        if (waddr_i == 0) begin
          if (m_start || !m_en) m_drv = wdata_i[1];
          if (!m_start) m_en = wdata_i[2];
          m_start = wdata_i[0];
        end else if (!m_start) begin
          case (waddr_i)
            1: m_mode = wdata_i[0];
            2: m_degl = wdata_i; 3: m_thr = wdata_i;
            4: m_hmax = wdata_i; 5: m_hmin = wdata_i;
            6: m_lmax = wdata_i; 7: m_lmin = wdata_i;
            default: ;
          endcase
        end
      end
      m_lvl = m_flt; m_flt = nflt; m_dc = ndc; m_s2 = m_s1; m_s1 = err_ni;
      m_ph = nph; m_w = nw; m_skip = nskip; m_hok = nhok; m_cnt = ncnt;
    end
  end

  function automatic int m_read(int a);
    case (a)
      0: return m_en * 4 + m_drv * 2 + m_start;
      1: return m_mode; 2: return m_degl; 3: return m_thr;
      4: return m_hmax; 5: return m_hmin; 6: return m_lmax; 7: return m_lmin;
      8: return m_cnt;
      default: return 0;
    endcase
  endfunction

  function automatic int m_err();
    return (m_en && m_start && (m_mode ? (m_cnt > m_thr) : (m_flt == 0))) ? 1 : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk_i) begin
    #2;
    if (rst_ni && !done) begin
      chk("R7 R10 err_o model", int'(err_o), m_err());
      chk("R5 drv model", int'(drv_en_o), m_drv);
      chk("R9 rdata model", int'(rdata_o), m_read(int'(raddr_i)));
    end
  end

  always @(negedge clk_i) begin
    tick_cnt++;
    tick_i = (tick_cnt % tick_per == 0);
  end

  task automatic wr(int a, int d);
    @(negedge clk_i); we_i = 1'b1; waddr_i = AW'(a); wdata_i = DW'(d);
    @(negedge clk_i); we_i = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk_i); raddr_i = AW'(a);
    @(posedge clk_i); #2; v = int'(rdata_o);
    raddr_i = 4'd8;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic period(int hi, int lo);
    @(negedge clk_i); err_ni = 1'b1; cyc(hi);
    err_ni = 1'b0; cyc(lo);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v;
    cyc(3); rst_ni = 1'b1; cyc(2);
    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 4);
    rd(8, v); chk("R1 count", v, 0);
    chk("R1 err_o", int'(err_o), 0);
    chk("R1 drv", int'(drv_en_o), 0);
    // R5 drv ignored when enabled and stopped
    wr(0, 6); rd(0, v); chk("R5 drv ignored", v, 4);
    // level mode
    wr(2, 3); wr(1, 0); wr(0, 5);
    rd(0, v); chk("R3 started", v, 5);
    @(negedge clk_i); err_ni = 1'b0; cyc(3); err_ni = 1'b1; cyc(10);
    chk("R6 short pulse dropped", int'(err_o), 0);
    err_ni = 1'b0; cyc(10);
    chk("R7 level error", int'(err_o), 1);
    // R4 lock
    wr(1, 1); rd(1, v); chk("R4 mode locked", v, 0);
    wr(2, 9); rd(2, v); chk("R4 degl locked", v, 3);
    // R5 drv accepted while started
    wr(0, 7); chk("R5 drv set", int'(drv_en_o), 1);
    rd(0, v); chk("R5 ctrl", v, 7);
    // R3 stop
    wr(0, 6); cyc(2);
    chk("R3 stopped err", int'(err_o), 0);
    @(negedge clk_i); err_ni = 1'b1; cyc(10);
    // PWM mode setup
    wr(1, 1); wr(2, 1); wr(3, 4); wr(4, 6); wr(5, 3); wr(6, 6); wr(7, 3);
    rd(4, v); chk("R4 hmax written", v, 6);
    wr(0, 5);
    for (int i = 0; i < 6; i++) period(8, 8);
    rd(8, v); chk("R8 good periods", v, 0);
    chk("R10 no error", int'(err_o), 0);
    for (int i = 0; i < 4; i++) period(2, 8);
    @(negedge clk_i); err_ni = 1'b1; cyc(5);
    rd(8, v); chk("R9 plus two", v, 8);
    chk("R10 over threshold", int'(err_o), 1);
    @(negedge clk_i); err_ni = 1'b0; cyc(8);
    for (int i = 0; i < 12; i++) period(8, 8);
    rd(8, v); chk("R9 floor zero", v, 0);
    chk("R10 below threshold", int'(err_o), 0);
    @(negedge clk_i); err_ni = 1'b0; cyc(400);
    rd(8, v); chk("R11 R9 stuck saturates", v, 31);
    chk("R11 error", int'(err_o), 1);
    wr(0, 4); wr(0, 5);
    rd(8, v); chk("R12 cleared", v, 0);
    // R2 disabled
    wr(0, 4); wr(0, 0);
    rd(0, v); chk("R2 disabled", v, 0);
    wr(0, 2); chk("R5 drv when disabled", int'(drv_en_o), 1);
    wr(0, 3);
    @(negedge clk_i); err_ni = 1'b0; cyc(300);
    chk("R2 no error pwm", int'(err_o), 0);
    rd(8, v); chk("R2 count frozen", v, 0);
    wr(0, 2); wr(1, 0); wr(0, 3); cyc(20);
    chk("R2 no error level", int'(err_o), 0);
    cyc(2);
    finish_run();
  end
endmodule